// File: doc/BRIEF.md
# Timer-Driven Configurable Data Shifter

This block is a serial shift engine that works beside an external baud timer. It runs in one of two modes. In transmit mode, software places a word in the holding buffer. A start pulse from the timer, or the first clock edge after it, moves the word into a shift register, and the register drives an output pin one bit per timer clock edge. In receive mode, the block samples an input pin on each selected timer clock edge. After a full word it moves the collected bits into the holding buffer.

Either edge of the timer clock can be chosen as the shift edge. An option delays the transmit load until the first shift edge. Together these two settings cover both clock phases of a synchronous serial link. The buffer is written and read through one of four views: plain, fully bit-reversed, byte-reversed, and bit-reversed inside each byte. These views let software run MSB-first transfers without a direction setting. A single flag reports that the transmit buffer may be refilled or that a received word is waiting, and it can drive an interrupt or DMA request.

Top module: `shifter_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the block sets `buf_flag` to 1 in transmit mode (`cfg_rx`=0) and 0 in receive mode, and clears the buffer and the shift register, so `pin_out` and a plain `rd_data` read 0.
- R2: `tmr_clk` is sampled on each `clk` edge. A shift edge is a 0-to-1 change between consecutive samples when `cfg_fall`=0, or a 1-to-0 change when `cfg_fall`=1.
- R3: In transmit mode with `cfg_ld_first`=0, a `tmr_start` pulse copies the buffer into the shift register and sets `buf_flag`. On the next cycle `pin_out` shows buffer bit 0.
- R4: In transmit mode, each later shift edge moves `pin_out` to the next higher bit of the loaded word. After all 32 bits it outputs 0.
- R5: In transmit mode with `cfg_ld_first`=1, `tmr_start` loads nothing. The first shift edge after it copies the buffer into the shift register and sets `buf_flag`, and `pin_out` shows bit 0 from the next cycle.
- R6: In receive mode, each shift edge samples `pin_in`. On the 32nd edge after the last `tmr_start` or completed word, the buffer takes the word with the first sampled bit in bit 0, and `buf_flag` sets. `tmr_start` restarts the bit count.
- R7: Views are encoded as follows. `rd_view` selects how the buffer reaches `rd_data`: 0 plain, 1 full bit reversal (out[i]=buf[31-i]), 2 byte reversal (out byte b = buf byte 3-b), 3 bit reversal inside each byte (out[8b+j]=buf[8b+7-j]). A transmit write stores `wr_data` through the same mapping, chosen by `wr_view`.
- R8: In transmit mode, `wr_en` stores the word and clears `buf_flag`. It wins over a load in the same cycle, and that load takes the old buffer.
- R9: In receive mode, `rd_en` clears `buf_flag`. A word completing in the same cycle wins and leaves the flag set. No other event clears the flag.
- R10: In receive mode, `wr_en` leaves the buffer unchanged and `pin_out` stays 0. In transmit mode, `rd_en` has no effect.
- R11: When `tmr_start` and a shift edge fall in the same cycle, only the start action happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx | input | 1 | 1 selects receive, 0 transmit |
| cfg_fall | input | 1 | 1 shifts on falling timer clock edge |
| cfg_ld_first | input | 1 | Transmit load waits for first shift edge |
| tmr_clk | input | 1 | Shift clock level from the timer |
| tmr_start | input | 1 | Transfer start pulse from the timer |
| pin_in | input | 1 | Serial data input |
| pin_out | output | 1 | Serial data output |
| wr_en | input | 1 | Buffer write strobe |
| wr_view | input | 2 | View used for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Buffer read strobe |
| rd_view | input | 2 | View used for the read |
| rd_data | output | 32 | Buffer as seen through `rd_view` |
| buf_flag | output | 1 | Buffer empty (transmit) or full (receive) |

## Verification
On every cycle, the assertions check how the flag behaves: a transmit write clears it, a completed receive word sets it, and it holds unless a strobe arrives. They also check that the pin shows bit 0 right after a start-time load, and that an unarmed transmit shift edge shifts the register by exactly one place. Only the bench scenarios can show the bit order of whole words under each view and edge selection. They also show the delayed load of the phase-one option, the restart of the receive count by a start pulse, and the same-cycle priority between a strobe and a load or completion.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int DEF_W = 32;

    typedef enum logic [1:0] {
        VIEW_PLAIN   = 2'd0,
        VIEW_BITREV  = 2'd1,
        VIEW_BYTEREV = 2'd2,
        VIEW_INBYTE  = 2'd3
    } view_e;

    typedef struct packed {
        logic rx;
        logic fall;
        logic ld_first;
    } shf_cfg_t;
endpackage

// File: rtl/shf_edge.sv
module shf_edge (
    input  logic clk,
    input  logic rst,
    input  logic tclk,
    input  logic fall_sel,
    output logic shift
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= tclk;
    end

    assign rise  = tclk & ~prev_q;
    assign fall  = ~tclk & prev_q;
    assign shift = fall_sel ? fall : rise;
endmodule

// File: rtl/shf_view.sv
module shf_view
    import shf_pkg::*;
#(
    parameter int WIDTH = DEF_W
) (
    input  view_e            sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NBYTES = WIDTH / 8;

    logic [WIDTH-1:0] bitrev, byterev, inbyte;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int B = i / 8;
        localparam int J = i % 8;
        assign bitrev[i]  = din[WIDTH-1-i];
        assign byterev[i] = din[8*(NBYTES-1-B) + J];
        assign inbyte[i]  = din[8*B + 7 - J];
    end

    always_comb begin
        unique case (sel)
            VIEW_PLAIN:   dout = din;
            VIEW_BITREV:  dout = bitrev;
            VIEW_BYTEREV: dout = byterev;
            default:      dout = inbyte;
        endcase
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int WIDTH = DEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  shf_cfg_t         cfg,
    input  logic             start,
    input  logic             shift,
    input  logic             pin_in,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] sr_o,
    output logic             take,
    output logic             done,
    output logic [WIDTH-1:0] rx_word
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             arm_q;

    assign rx_word = {pin_in, sr_q[WIDTH-1:1]};
    assign take = !cfg.rx && ((start && !cfg.ld_first) || (!start && shift && arm_q));
    assign done = cfg.rx && !start && shift && (cnt_q == LAST);
    assign sr_o = sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
            arm_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            arm_q <= !cfg.rx && cfg.ld_first;
            if (take) sr_q <= load_word;
        end else if (shift) begin
            if (cfg.rx) begin
                sr_q  <= rx_word;
                cnt_q <= done ? '0 : cnt_q + 1'b1;
            end else if (arm_q) begin
                sr_q  <= load_word;
                arm_q <= 1'b0;
            end else begin
                sr_q <= sr_q >> 1;
            end
        end
    end

    // R4: an unarmed transmit shift edge moves the register by one place
    assert_tx_shift_one_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg.rx && shift && !start && !arm_q) |=> (sr_q == ($past(sr_q) >> 1)));
endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = DEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rx,
    input  logic             cfg_fall,
    input  logic             cfg_ld_first,
    input  logic             tmr_clk,
    input  logic             tmr_start,
    input  logic             pin_in,
    output logic             pin_out,
    input  logic             wr_en,
    input  logic [1:0]       wr_view,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_view,
    output logic [WIDTH-1:0] rd_data,
    output logic             buf_flag
);
    shf_cfg_t         cfg;
    logic             shift, take, done;
    logic [WIDTH-1:0] sr, rx_word, wr_mapped, buf_q;
    logic             flag_q;

    assign cfg = '{rx: cfg_rx, fall: cfg_fall, ld_first: cfg_ld_first};

    shf_edge i_edge (
        .clk(clk), .rst(rst), .tclk(tmr_clk), .fall_sel(cfg_fall), .shift(shift)
    );

    shf_core #(.WIDTH(WIDTH)) i_core (
        .clk(clk), .rst(rst), .cfg(cfg), .start(tmr_start), .shift(shift),
        .pin_in(pin_in), .load_word(buf_q), .sr_o(sr), .take(take),
        .done(done), .rx_word(rx_word)
    );

    shf_view #(.WIDTH(WIDTH)) i_wr_view (
        .sel(view_e'(wr_view)), .din(wr_data), .dout(wr_mapped)
    );

    shf_view #(.WIDTH(WIDTH)) i_rd_view (
        .sel(view_e'(rd_view)), .din(buf_q), .dout(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            flag_q <= !cfg_rx;
        end else if (!cfg_rx) begin
            if (wr_en) begin
                buf_q  <= wr_mapped;
                flag_q <= 1'b0;
            end else if (take) begin
                flag_q <= 1'b1;
            end
        end else begin
            if (done) begin
                buf_q  <= rx_word;
                flag_q <= 1'b1;
            end else if (rd_en) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign pin_out  = cfg_rx ? 1'b0 : sr[0];
    assign buf_flag = flag_q;

    // R8: a transmit write always leaves the flag clear
    assert_tx_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rx && wr_en) |=> !buf_flag);

    // R6: a completed receive word raises the flag
    assert_rx_done_sets_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> buf_flag);

    // R9: the flag only drops on a strobe
    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (buf_flag && !wr_en && !rd_en) |=> buf_flag);

    // R3: start-time load puts buffer bit 0 on the pin
    assert_load_pin_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rx && !cfg_ld_first && tmr_start) |=> (pin_out == $past(buf_q[0])));
endmodule

// File: tb/test_shifter_unit.sv
module test_shifter_unit;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_rx = 1'b0, cfg_fall = 1'b0, cfg_ld_first = 1'b0;
    logic tmr_clk = 1'b0, tmr_start = 1'b0, pin_in = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_view = 2'd0, rd_view = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic pin_out, buf_flag;
    logic [W-1:0] rd_data;

    shifter_unit #(.WIDTH(W)) i_shifter_unit (
        .clk(clk), .rst(rst), .cfg_rx(cfg_rx), .cfg_fall(cfg_fall),
        .cfg_ld_first(cfg_ld_first), .tmr_clk(tmr_clk), .tmr_start(tmr_start),
        .pin_in(pin_in), .pin_out(pin_out), .wr_en(wr_en), .wr_view(wr_view),
        .wr_data(wr_data), .rd_en(rd_en), .rd_view(rd_view), .rd_data(rd_data),
        .buf_flag(buf_flag)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit tx_q[$];
    bit rx_q[$];
    logic [W-1:0] m_buf;
    bit m_flag, m_arm, m_prev;

    function automatic logic [W-1:0] mview(logic [W-1:0] x, logic [1:0] v);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) begin
            case (v)
                2'd0: y[i] = x[i];
                2'd1: y[i] = x[W-1-i];
                2'd2: y[i] = x[8*(3 - i/8) + i%8];
                default: y[i] = x[8*(i/8) + 7 - i%8];
            endcase
        end
        return y;
    endfunction

    task automatic model_load();
        tx_q.delete();
        for (int i = 0; i < W; i++) tx_q.push_back(m_buf[i]);
    endtask

    task automatic model_step();
        bit rise, fall, sh, take, done;
        logic [W-1:0] word;
        if (rst) begin
            tx_q.delete(); rx_q.delete();
            m_buf = '0; m_flag = !cfg_rx; m_arm = 0; m_prev = 0;
            return;
        end
        rise = tmr_clk && !m_prev;
        fall = !tmr_clk && m_prev;
        m_prev = tmr_clk;
        sh = cfg_fall ? fall : rise;
        take = 0; done = 0; word = '0;
        if (tmr_start) begin
            rx_q.delete();
            m_arm = 0;
            if (!cfg_rx) begin
                if (cfg_ld_first) m_arm = 1;
                else begin model_load(); take = 1; end
            end
        end else if (sh) begin
            if (cfg_rx) begin
                rx_q.push_back(pin_in);
                if (rx_q.size() == W) begin
                    for (int i = 0; i < W; i++) word[i] = rx_q[i];
                    rx_q.delete();
                    done = 1;
                end
            end else if (m_arm) begin
                model_load(); m_arm = 0; take = 1;
            end else if (tx_q.size() > 0) begin
                void'(tx_q.pop_front());
            end
        end
        if (!cfg_rx) begin
            if (wr_en) begin m_buf = mview(wr_data, wr_view); m_flag = 0; end
            else if (take) m_flag = 1;
        end else begin
            if (done) begin m_buf = word; m_flag = 1; end
            else if (rd_en) m_flag = 0;
        end
    endtask

    task automatic compare();
        logic exp_pin;
        logic [W-1:0] exp_rd;
        exp_pin = (!cfg_rx && tx_q.size() > 0) ? logic'(tx_q[0]) : 1'b0;
        exp_rd  = mview(m_buf, rd_view);
        vectors++;
        if (pin_out !== exp_pin || buf_flag !== m_flag || rd_data !== exp_rd) begin
            miscompares++;
            $display("FAIL %s: pin=%0b flag=%0b rd=%h expected pin=%0b flag=%0b rd=%h",
                     cur_req, pin_out, buf_flag, rd_data, exp_pin, m_flag, exp_rd);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit rx, bit fall, bit ldf);
        rst = 1; cfg_rx = rx; cfg_fall = fall; cfg_ld_first = ldf;
        tmr_clk = 0; tmr_start = 0; wr_en = 0; rd_en = 0;
        tick(); tick();
        rst = 0;
    endtask

    task automatic pulse();
        tmr_clk = 1; tick();
        tmr_clk = 0; tick();
    endtask

    task automatic start();
        tmr_start = 1; tick(); tmr_start = 0;
    endtask

    task automatic write(logic [W-1:0] d, logic [1:0] v);
        wr_en = 1; wr_data = d; wr_view = v; tick(); wr_en = 0;
    endtask

    task automatic tx_collect(output logic [W-1:0] got);
        got[0] = pin_out;
        for (int k = 1; k < W; k++) begin
            pulse();
            got[k] = pin_out;
        end
        pulse();
    endtask

    task automatic rx_feed(logic [W-1:0] d);
        for (int k = 0; k < W; k++) begin
            pin_in = d[k];
            pulse();
        end
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [W-1:0] got, d;

        cur_req = "R1";
        do_reset(0, 0, 0);
        chk(buf_flag === 1'b1 && pin_out === 1'b0 && rd_data === '0, "R1 tx reset", {31'd0, buf_flag}, 1);

        // transmit, start-time load, rising edge
        cur_req = "R3";
        d = 32'hA5C3_0F96;
        write(d, 2'd0);
        chk(buf_flag === 1'b0, "R8 write clears flag", {31'd0, buf_flag}, 0);
        start();
        chk(buf_flag === 1'b1 && pin_out === d[0], "R3 load on start", {31'd0, pin_out}, {31'd0, d[0]});
        cur_req = "R4";
        tx_collect(got);
        chk(got === d, "R4 LSB-first word", got, d);
        chk(pin_out === 1'b0, "R4 zero after word", {31'd0, pin_out}, 0);

        // MSB-first via bit-reversed write view
        cur_req = "R7";
        d = 32'h8001_3C7E;
        write(d, 2'd1);
        start();
        tx_collect(got);
        chk(got === mview(d, 2'd1), "R7 MSB-first transmit", got, mview(d, 2'd1));

        // start coincident with a shift edge
        cur_req = "R11";
        d = 32'h0000_0003;
        write(d, 2'd0);
        tmr_clk = 1; tmr_start = 1; tick(); tmr_start = 0;
        chk(pin_out === 1'b1, "R11 start wins over shift", {31'd0, pin_out}, 1);
        tmr_clk = 0; tick();

        // phase-one: load on first falling edge
        cur_req = "R5";
        do_reset(0, 1, 1);
        d = 32'h1234_5679;
        write(d, 2'd0);
        start();
        chk(buf_flag === 1'b0 && pin_out === 1'b0, "R5 no load at start", {31'd0, buf_flag}, 0);
        tmr_clk = 1; tick();
        chk(buf_flag === 1'b0, "R2 rising edge ignored with fall select", {31'd0, buf_flag}, 0);
        tmr_clk = 0; tick();
        chk(buf_flag === 1'b1 && pin_out === d[0], "R5 load on first edge", {31'd0, pin_out}, {31'd0, d[0]});
        tx_collect(got);
        chk(got === d, "R5 word after delayed load", got, d);

        // receive, rising edge
        cur_req = "R6";
        do_reset(1, 0, 0);
        chk(buf_flag === 1'b0, "R1 rx reset flag", {31'd0, buf_flag}, 0);
        d = 32'hDEAD_B00F;
        start();
        for (int k = 0; k < W - 1; k++) begin pin_in = d[k]; pulse(); end
        chk(buf_flag === 1'b0, "R6 flag low before last bit", {31'd0, buf_flag}, 0);
        pin_in = d[W-1]; pulse();
        chk(buf_flag === 1'b1, "R6 flag after word", {31'd0, buf_flag}, 1);
        cur_req = "R7";
        for (int v = 0; v < 4; v++) begin
            rd_view = 2'(v); tick();
            chk(rd_data === mview(d, 2'(v)), "R7 read view", rd_data, mview(d, 2'(v)));
        end
        rd_view = 0;
        cur_req = "R10";
        write(32'h5555_AAAA, 2'd0);
        chk(rd_data === d && pin_out === 1'b0, "R10 rx write ignored", rd_data, d);
        cur_req = "R9";
        rd_en = 1; tick(); rd_en = 0;
        chk(buf_flag === 1'b0, "R9 read clears flag", {31'd0, buf_flag}, 0);

        // receive, falling edge, count restarted by start
        cur_req = "R6";
        do_reset(1, 1, 0);
        for (int k = 0; k < 5; k++) begin pin_in = 1'b1; pulse(); end
        start();
        d = 32'h0F1E_2D3C;
        rx_feed(d);
        chk(buf_flag === 1'b1 && rd_data === d, "R6 falling edge word after restart", rd_data, d);

        // random traffic against the model
        cur_req = "R2";
        for (int r = 0; r < 8; r++) begin
            do_reset(r[0], r[1], r[2]);
            for (int c = 0; c < 600; c++) begin
                tmr_clk   = ($urandom_range(0, 2) == 0) ? ~tmr_clk : tmr_clk;
                tmr_start = ($urandom_range(0, 50) == 0);
                wr_en     = ($urandom_range(0, 40) == 0);
                rd_en     = ($urandom_range(0, 10) == 0);
                pin_in    = 1'($urandom());
                wr_view   = 2'($urandom());
                rd_view   = 2'($urandom());
                wr_data   = $urandom();
                tick();
            end
            tmr_start = 0; wr_en = 0; rd_en = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule